// File: doc/BRIEF.md
# Aligned Mantissa Add/Subtract Stage

This stage sits in a floating-point adder pipeline directly after exponent alignment. Each cycle it may accept two operands that already share one exponent; each operand carries a sign bit and an extended mantissa. Operands with the same sign have their mantissas summed. Operands with opposite signs have the smaller magnitude taken from the larger, so the resulting magnitude is never negative and its sign is chosen on a separate path.

One magnitude comparator and one shared adder/subtractor do all the work. Before the operation, both mantissas gain a zero bit on top, so the result is one bit wider than the inputs. A carry lands in the top bit and is passed on untouched for the later normalisation stage. The exponent passes straight through. Every output, including a valid flag, is registered and appears one clock after the input was sampled as valid.

Top module: `mant_addsub_stage`

## Requirements
- R1: After reset, outValid is 0 and outMant, outSign and outExp are all 0.
- R2: outValid is 1 exactly in the cycle after a rising clock edge where inValid was 1. Otherwise it is 0.
- R3: With inSignA equal to inSignB, outMant is the (MANT_W+1)-bit sum of the two zero-extended mantissas and outSign equals inSignA.
- R4: With different signs and inMantA >= inMantB, outMant is inMantA - inMantB and outSign is inSignA. A tie is handled by R6.
- R5: With different signs and inMantA < inMantB, outMant is inMantB - inMantA and outSign is inSignB.
- R6: With different signs and equal mantissas, outMant is 0 and outSign is 0 (positive).
- R7: outExp equals the inExp sampled together with inValid.
- R8: A carry from the sum appears in outMant bit MANT_W (bit 27 by default) and is kept, not folded or dropped.
- R9: When inValid is 0 at an edge, outMant, outSign and outExp keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands present this cycle |
| inSignA | input | 1 | Sign of operand A (1 = negative) |
| inSignB | input | 1 | Sign of operand B |
| inExp | input | EXP_W | Shared exponent of both operands |
| inMantA | input | MANT_W | Aligned mantissa A |
| inMantB | input | MANT_W | Aligned mantissa B |
| outValid | output | 1 | Result registered this cycle |
| outSign | output | 1 | Result sign |
| outExp | output | EXP_W | Passed-through exponent |
| outMant | output | MANT_W+1 | Result magnitude including carry bit |

## Verification
The operand pairs cover every combination of sign relation and magnitude order:
- equal signs, both positive and both negative, with and without a carry into the top bit;
- opposite signs with A larger;
- opposite signs with B larger;
- opposite signs with an exact tie;
- all-ones and zero mantissas.

Each case tells the path choice apart. A swapped subtraction order produces a wrapped huge value. A wrong sign pick shows up as the other sign. A dropped carry loses bit 27. A tie that keeps A's sign fails on negative A. Idle cycles between operations check that the result holds and that valid drops.

// File: rtl/mant_addsub_pkg.sv
package mant_addsub_pkg;
  typedef struct packed {
    logic load;     // capture new result
    logic doSub;    // subtract instead of add
    logic swapOps;  // compute B - A
    logic zeroSign; // force positive sign
  } addsub_ctrl_t;
endpackage

// File: rtl/mant_addsub_ctrl.sv
module mant_addsub_ctrl
  import mant_addsub_pkg::*;
(
  input  logic         inValid,
  input  logic         signA,
  input  logic         signB,
  input  logic         mantGe,
  input  logic         mantEq,
  output addsub_ctrl_t ctrl
);
  logic signsEqual;

  always_comb begin
    signsEqual    = (signA == signB);
    ctrl.load     = inValid;
    ctrl.doSub    = !signsEqual;
    ctrl.swapOps  = !signsEqual && !mantGe;
    ctrl.zeroSign = !signsEqual && mantEq;
  end
endmodule

// File: rtl/mant_addsub_dp.sv
module mant_addsub_dp
  import mant_addsub_pkg::*;
#(
  parameter int MANT_W = 27,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  addsub_ctrl_t      ctrl,
  input  logic              signA,
  input  logic              signB,
  input  logic [EXP_W-1:0]  expIn,
  input  logic [MANT_W-1:0] mantA,
  input  logic [MANT_W-1:0] mantB,
  output logic              mantGe,
  output logic              mantEq,
  output logic              validQ,
  output logic              signQ,
  output logic [EXP_W-1:0]  expQ,
  output logic [MANT_W:0]   mantQ
);
  localparam int EXT_W = MANT_W + 1;

  logic [EXT_W-1:0] extA, extB, opL, opR, result;
  logic             signNext;

  always_comb begin
    extA   = {1'b0, mantA};
    extB   = {1'b0, mantB};
    mantGe = (mantA >= mantB);
    mantEq = (mantA == mantB);
    opL    = ctrl.swapOps ? extB : extA;
    opR    = ctrl.swapOps ? extA : extB;
    result = ctrl.doSub ? (opL - opR) : (opL + opR);
    if (ctrl.zeroSign)     signNext = 1'b0;
    else if (ctrl.swapOps) signNext = signB;
    else                   signNext = signA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      signQ  <= 1'b0;
      expQ   <= '0;
      mantQ  <= '0;
    end else begin
      validQ <= ctrl.load;
      if (ctrl.load) begin
        signQ <= signNext;
        expQ  <= expIn;
        mantQ <= result;
      end
    end
  end
endmodule

// File: rtl/mant_addsub_stage.sv
module mant_addsub_stage
  import mant_addsub_pkg::*;
#(
  parameter int MANT_W = 27,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSignA,
  input  logic              inSignB,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMantA,
  input  logic [MANT_W-1:0] inMantB,
  output logic              outValid,
  output logic              outSign,
  output logic [EXP_W-1:0]  outExp,
  output logic [MANT_W:0]   outMant
);
  addsub_ctrl_t ctrl;
  logic         mantGe, mantEq;

  mant_addsub_ctrl u_ctrl (
    .inValid(inValid), .signA(inSignA), .signB(inSignB),
    .mantGe(mantGe), .mantEq(mantEq), .ctrl(ctrl)
  );

  mant_addsub_dp #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .signA(inSignA), .signB(inSignB), .expIn(inExp),
    .mantA(inMantA), .mantB(inMantB),
    .mantGe(mantGe), .mantEq(mantEq),
    .validQ(outValid), .signQ(outSign), .expQ(outExp), .mantQ(outMant)
  );
endmodule

// File: rtl/mant_addsub_checker.sv
module mant_addsub_checker #(
  parameter int MANT_W = 27,
  parameter int EXP_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inSignA,
  input logic              inSignB,
  input logic [EXP_W-1:0]  inExp,
  input logic [MANT_W-1:0] inMantA,
  input logic [MANT_W-1:0] inMantB,
  input logic              outValid,
  input logic              outSign,
  input logic [EXP_W-1:0]  outExp,
  input logic [MANT_W:0]   outMant
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid))); // R2
  AST_EXP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outExp == $past(inExp))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && $past(rstN)) |=> ($stable(outMant) && $stable(outSign) && $stable(outExp))); // R9
  AST_SAME_SIGN_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSignA == inSignB) |=> (outSign == $past(inSignA))); // R3
  AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSignA != inSignB && inMantA == inMantB) |=> (outMant == '0 && !outSign)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSignA != inSignB) |=> !outMant[MANT_W]); // R4 R5
endmodule

bind mant_addsub_stage mant_addsub_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_mant_addsub_stage.sv
module sim_mant_addsub_stage;
  localparam int MW = 27;
  localparam int EW = 10;
  localparam int NV = 10;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inSignA = 1'b0, inSignB = 1'b0;
  logic [EW-1:0] inExp = '0;
  logic [MW-1:0] inMantA = '0, inMantB = '0;
  logic outValid, outSign;
  logic [EW-1:0] outExp;
  logic [MW:0] outMant;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mant_addsub_stage u0 (.*);

  // {sA, sB, mA, mB}
  localparam logic [2*MW+1:0] VEC [NV] = '{
    {1'b0, 1'b0, 27'd100, 27'd23},
    {1'b1, 1'b1, 27'h7FFFFFF, 27'h0000001},
    {1'b0, 1'b0, 27'h7FFFFFF, 27'h7FFFFFF},
    {1'b0, 1'b1, 27'd5000, 27'd1234},
    {1'b1, 1'b0, 27'd5000, 27'd1234},
    {1'b0, 1'b1, 27'd7, 27'd9000},
    {1'b1, 1'b0, 27'd0, 27'h7FFFFFF},
    {1'b1, 1'b0, 27'd4242, 27'd4242},
    {1'b0, 1'b1, 27'h4000000, 27'h4000000},
    {1'b0, 1'b1, 27'h7FFFFFF, 27'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic sA, input logic sB, input logic [MW-1:0] a, input logic [MW-1:0] b);
    if (sA == sB) return "R3";
    if (a == b) return "R6";
    if (a > b) return "R4";
    return "R5";
  endfunction

  task automatic apply(input logic sA, input logic sB, input logic [MW-1:0] a,
                       input logic [MW-1:0] b, input logic [EW-1:0] e);
    logic [MW:0] em;
    logic es;
    string rq;
    rq = reqOf(sA, sB, a, b);
    if (sA == sB) begin em = {1'b0, a} + {1'b0, b}; es = sA; end
    else if (a == b) begin em = '0; es = 1'b0; end
    else if (a > b) begin em = {1'b0, a} - {1'b0, b}; es = sA; end
    else begin em = {1'b0, b} - {1'b0, a}; es = sB; end
    @(negedge clk);
    inValid = 1; inSignA = sA; inSignB = sB; inMantA = a; inMantB = b; inExp = e;
    @(negedge clk);
    inValid = 0;
    check({rq, " mant"}, 64'(outMant), 64'(em));
    check({rq, " sign"}, 64'(outSign), 64'(es));
    check("R7 exp", 64'(outExp), 64'(e));
    check("R2 valid", 64'(outValid), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(outValid), 0);
    check("R1 mant", 64'(outMant), 0);
    check("R1 sign", 64'(outSign), 0);
    check("R1 exp", 64'(outExp), 0);
    rstN = 1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][2*MW+1], VEC[i][2*MW], VEC[i][2*MW-1:MW], VEC[i][MW-1:0], EW'(i*37+5));
    end
    // R8: carry kept in the top bit
    apply(1'b0, 1'b0, 27'h4000000, 27'h4000000, 10'h3FF);
    check("R8 carry", 64'(outMant[MW]), 1);
    // R9: idle cycle, changed inputs, outputs held
    @(negedge clk);
    inSignA = 1; inSignB = 0; inMantA = 27'd1; inMantB = 27'd99; inExp = 10'd1;
    @(negedge clk);
    check("R9 mant hold", 64'(outMant), 64'h8000000);
    check("R9 exp hold", 64'(outExp), 64'h3FF);
    check("R9 sign hold", 64'(outSign), 0);
    check("R2 valid low", 64'(outValid), 0);
    // R6: tie with negative A must still give positive zero
    apply(1'b1, 1'b0, 27'd77, 27'd77, 10'd12);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); mismatched++; $display("FAIL watchdog expired"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule